// File: doc/BRIEF.md
# Pixel Hit Timestamp Recorder

This block is the digital side of a single time-stamping pixel. A shared timestamp bus runs past every pixel, and a comparator output from the analog front end tells the pixel that a particle has crossed it. On each new rising edge of that hit signal, the block copies the timestamp present on the bus into the next free slot of a small local store. With the default parameters the store has two slots, so a pixel can keep both a first and a second crossing inside one bunch train.

Between trains the block is put into readout mode. It then presents its stored stamps oldest first, one per advance strobe. It raises an empty flag as soon as nothing unread is left, so a column sequencer can skip a quiet pixel at once. A train-start clear empties the store and rearms the pixel. Hits that arrive when every slot is full are dropped, and a sticky overflow flag records that this happened. The recorder accepts a new hit every second clock cycle, which at any practical clock rate is well above the few-MHz rate a pixel must sustain.

Top module: `pixel_ts_recorder`

## Requirements
- R1: After reset, `stored_cnt` is 0, `overflow` is 0, `rd_valid` is 0 and `empty` is 0 while `rd_mode` is low.
- R2: A rising edge on `hit_in` (high now, low in the previous cycle) while `rd_mode` is low, `train_clr` is low and `stored_cnt` is below DEPTH stores the `ts_bus` value of that cycle in slot `stored_cnt`. `stored_cnt` is one higher after that clock edge.
- R3: A `hit_in` that stays high over several cycles records exactly one timestamp, the one on the bus in its first high cycle.
- R4: Hits made of one high cycle followed by one low cycle are each recorded, so the sustained rate is one hit every two clock cycles.
- R5: A rising edge on `hit_in` when `stored_cnt` equals DEPTH stores nothing and leaves all stored stamps unchanged. It sets `overflow`, which stays at 1 until `train_clr`.
- R6: Rising edges on `hit_in` while `rd_mode` is high are ignored, and `stored_cnt` does not change.
- R7: While `rd_mode` is high, `rd_data` shows the oldest unread stamp with `rd_valid` at 1, stamps come out in recording order, and a cycle with `rd_adv` high moves to the next stamp after that clock edge.
- R8: While `rd_mode` is high and no unread stamp is left (this includes a pixel with no hits), `empty` is 1, `rd_valid` is 0 and `rd_data` is 0. While `rd_mode` is low, `empty` is 0.
- R9: `rd_adv` while `empty` is 1 has no effect: `empty` stays at 1 and `rd_data` stays at 0.
- R10: `train_clr` sets `stored_cnt` to 0, clears `overflow` and returns the read position to the first slot after one clock edge. It overrides a rising edge on `hit_in` in the same cycle, and that hit is not recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_bus | input | TS_W | Global timestamp bus |
| hit_in | input | 1 | Comparator hit signal, synchronous to clk |
| train_clr | input | 1 | Train-start clear |
| rd_mode | input | 1 | High during the readout gap between trains |
| rd_adv | input | 1 | Readout advance strobe |
| rd_data | output | TS_W | Oldest unread stamp, 0 when none |
| rd_valid | output | 1 | rd_data holds a stored stamp |
| empty | output | 1 | Readout mode with no unread stamp |
| overflow | output | 1 | Sticky flag: a hit was dropped because the store was full |
| stored_cnt | output | $clog2(DEPTH+1) | Number of stamps recorded this train |

## Verification
The edge-based properties assume that `hit_in` is already synchronous to `clk`, which means the direct input variant with SYNC_STAGES equal to 0. The bench uses that default and changes every input only on the falling edge. The checker also assumes that `rd_mode` and `train_clr` are plain level inputs whose order of use is arbitrary. The directed tests therefore also put a clear in the middle of a readout and a hit in the same cycle as a clear, and the properties still have to hold there.

// File: rtl/pixel_ts_pkg.sv
package pixel_ts_pkg;

   // Write-side decision made once per cycle
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_STORE = 2'd1,
      OP_DROP  = 2'd2,
      OP_CLEAR = 2'd3
   } rec_op_e;

   localparam int unsigned MAX_DEPTH       = 16;
   localparam int unsigned MAX_SYNC_STAGES = 4;

endpackage

// File: rtl/pts_hit_edge.sv
module pts_hit_edge #(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit_raw,
   output logic hit_rise
);

   logic hit_staged;
   logic hit_prev;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign hit_staged = hit_raw;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '0;
            end else begin
               chain <= {chain[SYNC_STAGES-1:0] , hit_raw} >> 0;
            end
         end
         assign hit_staged = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_prev <= 1'b0;
      end else begin
         hit_prev <= hit_staged;
      end
   end

   assign hit_rise = hit_staged & ~hit_prev;

endmodule

// File: rtl/pts_cell_bank.sv
module pts_cell_bank #(
   parameter int unsigned TS_W  = 14,
   parameter int unsigned DEPTH = 2,
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_idx,
   input  logic [TS_W-1:0]  wr_ts,
   input  logic [CNT_W-1:0] rd_idx,
   output logic [TS_W-1:0]  rd_ts
);

   logic [TS_W-1:0] cells [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_cell
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cells[i] <= '0;
            end else if (wr_en && (wr_idx == CNT_W'(i))) begin
               cells[i] <= wr_ts;
            end
         end
      end
   endgenerate

   always_comb begin
      rd_ts = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_idx == CNT_W'(i)) begin
            rd_ts = cells[i];
         end
      end
   end

endmodule

// File: rtl/pts_read_seq.sv
module pts_read_seq #(
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             rd_mode,
   input  logic             rd_adv,
   input  logic [CNT_W-1:0] stored_cnt,
   output logic [CNT_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic             empty
);

   logic [CNT_W-1:0] rd_pos;
   logic             pending;

   assign pending = (rd_pos < stored_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pos <= '0;
      end else if (clr) begin
         rd_pos <= '0;
      end else if (rd_mode && rd_adv && pending) begin
         rd_pos <= rd_pos + CNT_W'(1);
      end
   end

   assign rd_idx   = rd_pos;
   assign rd_valid = rd_mode & pending;
   assign empty    = rd_mode & ~pending;

endmodule

// File: rtl/pixel_ts_recorder.sv
module pixel_ts_recorder
   import pixel_ts_pkg::*;
#(
   parameter int unsigned TS_W        = 14,
   parameter int unsigned DEPTH       = 2,
   parameter int unsigned SYNC_STAGES = 0,
   localparam int unsigned CNT_W      = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TS_W-1:0]  ts_bus,
   input  logic             hit_in,
   input  logic             train_clr,
   input  logic             rd_mode,
   input  logic             rd_adv,
   output logic [TS_W-1:0]  rd_data,
   output logic             rd_valid,
   output logic             empty,
   output logic             overflow,
   output logic [CNT_W-1:0] stored_cnt
);

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   generate
      if (TS_W < 1) begin : g_bad_ts_w
         $error("pixel_ts_recorder: TS_W must be at least 1");
      end
      if (DEPTH < 1 || DEPTH > MAX_DEPTH) begin : g_bad_depth
         $error("pixel_ts_recorder: DEPTH out of range");
      end
      if (SYNC_STAGES > MAX_SYNC_STAGES) begin : g_bad_sync
         $error("pixel_ts_recorder: SYNC_STAGES out of range");
      end
   endgenerate

   logic             hit_rise;
   rec_op_e          op;
   logic [CNT_W-1:0] wr_cnt;
   logic             ovf_q;
   logic [CNT_W-1:0] rd_idx;
   logic [TS_W-1:0]  bank_ts;
   logic             seq_valid;

   pts_hit_edge #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_raw (hit_in),
      .hit_rise(hit_rise)
   );

   // Clear wins; hits are only taken outside readout
   always_comb begin
      op = OP_IDLE;
      if (train_clr) begin
         op = OP_CLEAR;
      end else if (hit_rise && !rd_mode) begin
         op = (wr_cnt == FULL_CNT) ? OP_DROP : OP_STORE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_cnt <= '0;
         ovf_q  <= 1'b0;
      end else begin
         unique case (op)
            OP_CLEAR: begin
               wr_cnt <= '0;
               ovf_q  <= 1'b0;
            end
            OP_STORE: wr_cnt <= wr_cnt + CNT_W'(1);
            OP_DROP:  ovf_q  <= 1'b1;
            default:  ;
         endcase
      end
   end

   pts_cell_bank #(
      .TS_W (TS_W),
      .DEPTH(DEPTH),
      .CNT_W(CNT_W)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (op == OP_STORE),
      .wr_idx(wr_cnt),
      .wr_ts (ts_bus),
      .rd_idx(rd_idx),
      .rd_ts (bank_ts)
   );

   pts_read_seq #(
      .CNT_W(CNT_W)
   ) u_rdseq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (train_clr),
      .rd_mode   (rd_mode),
      .rd_adv    (rd_adv),
      .stored_cnt(wr_cnt),
      .rd_idx    (rd_idx),
      .rd_valid  (seq_valid),
      .empty     (empty)
   );

   assign rd_data    = seq_valid ? bank_ts : '0;
   assign rd_valid   = seq_valid;
   assign overflow   = ovf_q;
   assign stored_cnt = wr_cnt;

endmodule

// File: rtl/pts_checker.sv
module pts_checker #(
   parameter int unsigned DEPTH       = 2,
   parameter int unsigned CNT_W       = 2,
   parameter int unsigned SYNC_STAGES = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hit_in,
   input logic             train_clr,
   input logic             rd_mode,
   input logic             rd_adv,
   input logic             rd_valid,
   input logic             empty,
   input logic             overflow,
   input logic [CNT_W-1:0] stored_cnt
);

   logic hit_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_d <= 1'b0;
      else        hit_d <= hit_in;
   end

   // R2: count never exceeds the number of slots
   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      stored_cnt <= CNT_W'(DEPTH));

   // R5: overflow is sticky until a clear
   p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !train_clr) |=> overflow);

   // R6: nothing is recorded during readout
   p_no_write_readout_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_mode && !train_clr) |=> (stored_cnt == $past(stored_cnt)));

   // R8: empty only in readout, and exclusive with valid there
   p_empty_in_readout_r8: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> rd_mode);
   p_empty_xor_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_mode |-> (empty != rd_valid));

   // R9: advancing an empty pixel keeps it empty
   p_adv_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_mode && empty && rd_adv && !train_clr) |=> (empty || !rd_mode));

   // R10: clear empties the store and the overflow flag
   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      train_clr |=> (stored_cnt == '0 && !overflow));

   generate
      if (SYNC_STAGES == 0) begin : g_edge_props
         // R2: a fresh edge with room is counted
         p_record_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_in && !hit_d && !rd_mode && !train_clr && stored_cnt < CNT_W'(DEPTH))
            |=> (stored_cnt == $past(stored_cnt) + CNT_W'(1)));
         // R3: a held hit adds nothing
         p_held_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_in && hit_d && !train_clr) |=> (stored_cnt == $past(stored_cnt)));
         // R5: an edge on a full pixel raises overflow
         p_full_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_in && !hit_d && !rd_mode && !train_clr && stored_cnt == CNT_W'(DEPTH))
            |=> (overflow && stored_cnt == CNT_W'(DEPTH)));
      end
   endgenerate

endmodule

bind pixel_ts_recorder pts_checker #(
   .DEPTH      (DEPTH),
   .CNT_W      (CNT_W),
   .SYNC_STAGES(SYNC_STAGES)
) u_pts_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hit_in    (hit_in),
   .train_clr (train_clr),
   .rd_mode   (rd_mode),
   .rd_adv    (rd_adv),
   .rd_valid  (rd_valid),
   .empty     (empty),
   .overflow  (overflow),
   .stored_cnt(stored_cnt)
);

// File: tb/tb_pixel_ts_recorder.sv
`timescale 1ns/1ps
module tb_pixel_ts_recorder;

   localparam int TS_W  = 14;
   localparam int DEPTH = 2;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [TS_W-1:0]  ts_bus = '0;
   logic             hit_in = 1'b0;
   logic             train_clr = 1'b0;
   logic             rd_mode = 1'b0;
   logic             rd_adv = 1'b0;
   logic [TS_W-1:0]  rd_data;
   logic             rd_valid;
   logic             empty;
   logic             overflow;
   logic [CNT_W-1:0] stored_cnt;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   pixel_ts_recorder #(.TS_W(TS_W), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .ts_bus(ts_bus), .hit_in(hit_in),
      .train_clr(train_clr), .rd_mode(rd_mode), .rd_adv(rd_adv),
      .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty),
      .overflow(overflow), .stored_cnt(stored_cnt)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // inputs change on the falling edge; outputs are read on the next falling edge
   task automatic cyc(input int n = 1);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic hit_pulse(input logic [TS_W-1:0] ts);
      ts_bus = ts; hit_in = 1'b1; cyc();
      hit_in = 1'b0; ts_bus = '0; cyc();
   endtask

   task automatic clear_train();
      train_clr = 1'b1; cyc(); train_clr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "stored_cnt", stored_cnt, 0);
      chk("R1", "overflow", overflow, 0);
      chk("R1", "rd_valid", rd_valid, 0);
      chk("R1", "empty", empty, 0);
      rd_mode = 1'b1; cyc();
      chk("R8", "empty with no hits", empty, 1);
      chk("R8", "rd_data with no hits", rd_data, 0);
      rd_mode = 1'b0; cyc();
   endtask

   task automatic t_two_hits_and_read();
      clear_train();
      ts_bus = 14'h1234; hit_in = 1'b1; cyc();
      chk("R2", "count after first hit", stored_cnt, 1);
      hit_in = 1'b0; cyc();
      ts_bus = 14'h0ABC; hit_in = 1'b1; cyc();
      chk("R4", "count after second hit", stored_cnt, 2);
      hit_in = 1'b0; cyc();
      chk("R2", "overflow after two hits", overflow, 0);
      rd_mode = 1'b1; cyc();
      chk("R7", "first stamp", rd_data, 14'h1234);
      chk("R7", "first valid", rd_valid, 1);
      chk("R8", "not empty", empty, 0);
      rd_adv = 1'b1; cyc(); rd_adv = 1'b0;
      chk("R7", "second stamp", rd_data, 14'h0ABC);
      rd_adv = 1'b1; cyc(); rd_adv = 1'b0;
      chk("R8", "empty after read", empty, 1);
      chk("R8", "rd_valid after read", rd_valid, 0);
      chk("R8", "rd_data after read", rd_data, 0);
      rd_adv = 1'b1; cyc(2); rd_adv = 1'b0;
      chk("R9", "empty after extra adv", empty, 1);
      chk("R9", "rd_data after extra adv", rd_data, 0);
      rd_mode = 1'b0; cyc();
      chk("R8", "empty outside readout", empty, 0);
      clear_train();
      chk("R10", "count after clear", stored_cnt, 0);
   endtask

   task automatic t_held_hit();
      clear_train();
      ts_bus = 14'h0111; hit_in = 1'b1; cyc();
      for (int k = 0; k < 4; k++) begin
         ts_bus = 14'h0200 + 14'(k); cyc();
      end
      hit_in = 1'b0; cyc();
      chk("R3", "count after held hit", stored_cnt, 1);
      rd_mode = 1'b1; cyc();
      chk("R3", "held hit stamp", rd_data, 14'h0111);
      rd_mode = 1'b0; cyc();
   endtask

   task automatic t_overflow();
      clear_train();
      hit_pulse(14'h3001);
      hit_pulse(14'h3002);
      hit_pulse(14'h3003);
      chk("R5", "count when full", stored_cnt, 2);
      chk("R5", "overflow set", overflow, 1);
      hit_pulse(14'h3004);
      chk("R5", "overflow sticky", overflow, 1);
      rd_mode = 1'b1; cyc();
      chk("R5", "slot 0 kept", rd_data, 14'h3001);
      rd_adv = 1'b1; cyc(); rd_adv = 1'b0;
      chk("R5", "slot 1 kept", rd_data, 14'h3002);
      rd_mode = 1'b0; cyc();
      chk("R5", "overflow still set", overflow, 1);
      clear_train();
      chk("R10", "overflow cleared", overflow, 0);
   endtask

   task automatic t_hit_in_readout();
      clear_train();
      rd_mode = 1'b1; cyc();
      hit_pulse(14'h0555);
      chk("R6", "count after readout hit", stored_cnt, 0);
      chk("R6", "still empty", empty, 1);
      rd_mode = 1'b0; cyc();
   endtask

   task automatic t_clear_priority();
      clear_train();
      ts_bus = 14'h0777; hit_in = 1'b1; train_clr = 1'b1; cyc();
      train_clr = 1'b0; hit_in = 1'b0; cyc();
      chk("R10", "hit with clear not stored", stored_cnt, 0);
   endtask

   task automatic t_clear_mid_read();
      clear_train();
      hit_pulse(14'h0A01);
      hit_pulse(14'h0A02);
      rd_mode = 1'b1; rd_adv = 1'b1; cyc(); rd_adv = 1'b0;
      chk("R7", "advanced to slot 1", rd_data, 14'h0A02);
      rd_mode = 1'b0;
      clear_train();
      hit_pulse(14'h0B0B);
      rd_mode = 1'b1; cyc();
      chk("R10", "read restarts at slot 0", rd_data, 14'h0B0B);
      rd_mode = 1'b0; cyc();
   endtask

   initial begin : main
      cyc(3);
      rst_n = 1'b1;
      cyc();
      t_reset();
      t_two_hits_and_read();
      t_held_hit();
      t_overflow();
      t_hit_in_readout();
      t_clear_priority();
      t_clear_mid_read();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule